// File: doc/BRIEF.md
# Video Field EDH Check Generator

This block computes two 16-bit error-detection check words for each field of a 10-bit parallel digital video stream and splices them into the stream it forwards. One check word covers every non-sync word of the field. The other covers only the active picture: the words between a start-of-active-video marker and the next end-of-active-video marker, on lines that are not vertically blanked. A sync detector upstream supplies per-word flags. These mark timing-reference words, the SAV and EAV positions, vertical blanking, the reserved ancillary payload slot and the end of each field.

At each field end the two running values are captured and the accumulators restart. During the next field, when the payload slot passes, the block replaces its six words with the captured values, a flag word and a checksum. A force input makes the block overwrite the slot even when no completed field is held. An active-low enable input turns the whole function off. A resync strobe, raised when a sync word is found in a new or unexpected place, discards all state. Timing-reference words are clipped before they are forwarded: values 000h to 003h become 000h, and values 3FCh to 3FFh become 3FFh.

Top module: `edh_check_gen`

## Requirements
- R1: `out_valid` equals `in_valid` one clock later. A valid word that is neither a timing-reference word nor a slot word being overwritten leaves the block unchanged one clock later.
- R2: A word flagged `trs` whose upper eight bits are all zero is forwarded as 000h. One whose upper eight bits are all one is forwarded as 3FFh. Other `trs` words pass unchanged.
- R3: Each check word starts at 0000h. For every counted word, the word's ten bits are fed LSB first into a 16-bit shift register with feedback polynomial x^16+x^12+x^5+1 (feedback = MSB xor data bit; shift left; xor 1021h when feedback is 1).
- R4: The full-field check counts every valid word that has neither `trs` nor `edh_slot` set.
- R5: The active check counts the same words, but only when they fall after a valid word with `sav` set and `vblank` low, and before the next valid word with `eav` set.
- R6: A `field_end` pulse captures both running values, including a word counted in the same cycle. It clears both accumulators and sets the held-valid flag.
- R7: The slot is the run of consecutive valid words with `edh_slot` high. Its first six words are replaced, in order, by: active low byte, active high byte, full low byte, full high byte, flags, checksum. Each byte word carries the byte in bits 7:0, even parity of those bits in bit 8, and the inverse of bit 8 in bit 9. The flags byte has bit 0 = held-valid and bit 1 = `force_new`; its other bits are zero. Slot words after the sixth pass unchanged.
- R8: Checksum word bits 8:0 are the sum, modulo 512, of bits 8:0 of the five preceding payload words. Bit 9 is the inverse of bit 8.
- R9: With `force_new` low, the slot is overwritten only while the held-valid flag is set. Otherwise slot words pass unchanged.
- R10: With `force_new` high, the slot is overwritten whether or not the held-valid flag is set.
- R11: While `edh_en_n` is high, no slot is overwritten. Both accumulators, both held values, the held-valid flag and the active window are cleared.
- R12: A `resync` pulse clears the same state as R11, and no slot word is overwritten in that cycle.
- R13: After reset, `out_valid` and `out_word` are zero, and the held values are zero. A forced insertion before any field end therefore carries zero check bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 10 | Input video word |
| trs | input | 1 | Word belongs to a timing-reference sequence |
| sav | input | 1 | Word is the last word of an SAV sequence |
| eav | input | 1 | Word is the last word of an EAV sequence |
| vblank | input | 1 | Current line is vertically blanked (sampled at SAV) |
| edh_slot | input | 1 | Word lies in the reserved check payload slot |
| field_end | input | 1 | Field boundary pulse |
| resync | input | 1 | New or misplaced sync position detected |
| edh_en_n | input | 1 | Active-low function enable |
| force_new | input | 1 | Overwrite the slot regardless of held state |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 10 | Output word with clipping and insertion applied |

## Verification
The fields sent mix blanked and unblanked lines, random picture and blanking data, and out-of-range timing words. A difference between the full-field and active check values therefore exposes a wrong window boundary or a blanking decision made at the wrong time. Slots are presented before any field has completed, after completed fields, after a resync, under force with zero held values, and while disabled and just after re-enabling. These cases separate the held-valid gating from the force path and from the state clearing. One field boundary coincides with a counted word, which shows whether that word lands in the captured value or in the next field.

// File: rtl/edh_pkg.sv
package edh_pkg;
  // number of payload words the block owns inside the slot
  localparam int PKT_LEN = 6;

  // order of the payload words inside the slot
  typedef enum logic [2:0] {
    PW_ACT_LO  = 3'd0,
    PW_ACT_HI  = 3'd1,
    PW_FULL_LO = 3'd2,
    PW_FULL_HI = 3'd3,
    PW_FLAGS   = 3'd4,
    PW_SUM     = 3'd5
  } pay_pos_e;
endpackage

// File: rtl/edh_crc_acc.sv
module edh_crc_acc #(
  parameter int WORD_W = 10,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic              latch,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  check
);
  logic [CRC_W-1:0] acc, acc_nxt;

  // one word, LSB first, through the feedback shift register
  function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c,
                                            input logic [WORD_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  always_comb acc_nxt = take ? step(acc, word) : acc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc   <= '0;
      check <= '0;
    end else if (latch) begin
      check <= acc_nxt;
      acc   <= '0;
    end else begin
      acc <= acc_nxt;
    end
  end

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (latch && !clr) |=> (acc == '0));
endmodule

// File: rtl/edh_inserter.sv
module edh_inserter
  import edh_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              slot,
  input  logic              go,
  input  logic              ok,
  input  logic              forced,
  input  logic [CRC_W-1:0]  crc_act,
  input  logic [CRC_W-1:0]  crc_full,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  localparam int IDX_W = $clog2(PKT_LEN + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] enc [PKT_LEN-1];
  logic [8:0]        sum;
  logic [WORD_W-1:0] pay;
  logic              ins;

  // byte with parity in bit 8 and its inverse in bit 9
  function automatic logic [WORD_W-1:0] enc8(input logic [7:0] b);
    logic [WORD_W-1:0] r;
    r      = '0;
    r[7:0] = b;
    r[8]   = ^b;
    r[9]   = ~(^b);
    return r;
  endfunction

  always_comb begin
    enc[PW_ACT_LO]  = enc8(crc_act[7:0]);
    enc[PW_ACT_HI]  = enc8(crc_act[15:8]);
    enc[PW_FULL_LO] = enc8(crc_full[7:0]);
    enc[PW_FULL_HI] = enc8(crc_full[15:8]);
    enc[PW_FLAGS]   = enc8({6'b0, forced, ok});
    sum = '0;
    for (int k = 0; k < PKT_LEN - 1; k++) sum = sum + enc[k][8:0];
    pay = in_word;
    if (idx < LAST - 1'b1) pay = enc[idx];
    else if (pay_pos_e'(idx) == PW_SUM) pay = {~sum[8], sum};
  end

  assign ins = in_valid && slot && (idx < LAST) && go;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      idx       <= '0;
    end else begin
      out_valid <= in_valid;
      out_word  <= ins ? pay : in_word;
      if (clr) idx <= '0;
      else if (in_valid) idx <= slot ? ((idx == LAST) ? idx : idx + 1'b1) : '0;
    end
  end

  p_parity_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(ins) && !$past(rst)) |-> (out_word[9] != out_word[8]));
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);
endmodule

// File: rtl/edh_check_gen.sv
module edh_check_gen #(
  parameter int WORD_W = 10,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              trs,
  input  logic              sav,
  input  logic              eav,
  input  logic              vblank,
  input  logic              edh_slot,
  input  logic              field_end,
  input  logic              resync,
  input  logic              edh_en_n,
  input  logic              force_new,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  localparam int NCHK = 2;  // 0: active picture, 1: full field

  logic [WORD_W-1:0] cw;
  logic              halt, in_act, held_ok, counted;
  logic [NCHK-1:0]   take;
  logic [CRC_W-1:0]  check [NCHK];

  // LSB clipping of timing-reference words
  always_comb begin
    cw = in_word;
    if (trs) begin
      if (in_word[WORD_W-1:2] == '0) cw = '0;
      else if (&in_word[WORD_W-1:2]) cw = '1;
    end
  end

  assign halt    = edh_en_n || resync;
  assign counted = in_valid && !trs && !edh_slot;
  assign take[0] = counted && in_act;
  assign take[1] = counted;

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      in_act  <= 1'b0;
      held_ok <= 1'b0;
    end else begin
      if (in_valid && sav) in_act <= !vblank;
      else if (in_valid && eav) in_act <= 1'b0;
      if (field_end) held_ok <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCHK; g++) begin : g_chk
    edh_crc_acc #(.WORD_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) u_acc (
      .clk(clk), .rst(rst), .clr(halt), .take(take[g]),
      .latch(field_end), .word(cw), .check(check[g]));
  end

  edh_inserter #(.WORD_W(WORD_W), .CRC_W(CRC_W)) u_ins (
    .clk(clk), .rst(rst), .clr(halt),
    .in_valid(in_valid), .in_word(cw), .slot(edh_slot),
    .go(!halt && (force_new || held_ok)),
    .ok(held_ok), .forced(force_new),
    .crc_act(check[0]), .crc_full(check[1]),
    .out_valid(out_valid), .out_word(out_word));

  p_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(trs) && !$past(edh_slot)) |-> (out_word == $past(in_word)));
  p_clip_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(trs) && !$past(edh_slot)) |->
      !(out_word inside {10'h001, 10'h002, 10'h003, 10'h3FC, 10'h3FD, 10'h3FE}));
  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!held_ok && check[0] == '0 && check[1] == '0 && !in_act));
  p_disabled_r11: assert property (@(posedge clk) disable iff (rst)
    (edh_en_n && in_valid && !trs) |=> (out_word == $past(in_word)));
endmodule

// File: tb/sim_edh_check_gen.sv
module sim_edh_check_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, trs = 0, sav = 0, eav = 0, vblank = 0, edh_slot = 0;
  logic field_end = 0, resync = 0, edh_en_n = 0, force_new = 0;
  logic [9:0] in_word = '0;
  logic out_valid;
  logic [9:0] out_word;

  always #2.5 clk = ~clk;

  edh_check_gen u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .trs(trs),
    .sav(sav), .eav(eav), .vblank(vblank), .edh_slot(edh_slot),
    .field_end(field_end), .resync(resync), .edh_en_n(edh_en_n),
    .force_new(force_new), .out_valid(out_valid), .out_word(out_word));

  int n_chk = 0, n_fail = 0, cycles = 0;
  string cur_req = "R13";

  // behavioural reference state
  logic [15:0] m_acc_a, m_acc_f, m_held_a, m_held_f;
  bit m_ok, m_act, started;
  int m_idx;
  logic e_valid;
  logic [9:0] e_word;
  string e_tag;

  function automatic logic [15:0] crc_of(input logic [15:0] c, input logic [9:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 10; i++) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [9:0] bytew(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    return {(ones % 2 == 0), (ones % 2 == 1), b};
  endfunction

  function automatic logic [9:0] payload(input int k);
    logic [7:0] b [5];
    int s = 0;
    b[0] = m_held_a[7:0];  b[1] = m_held_a[15:8];
    b[2] = m_held_f[7:0];  b[3] = m_held_f[15:8];
    b[4] = {6'b0, force_new, m_ok};
    if (k < 5) return bytew(b[k]);
    for (int i = 0; i < 5; i++) s += bytew(b[i]) & 10'h1FF;
    s = s % 512;
    return {~s[8], s[8:0]};
  endfunction

  function automatic string pos_tag(input int k);
    case (k)
      0, 1: return "R5 R3";
      2, 3: return "R4 R3";
      4: return "R6 R10";
      default: return "R8 R7";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [9:0] w;
    if (rst) begin
      m_acc_a = 0; m_acc_f = 0; m_held_a = 0; m_held_f = 0;
      m_ok = 0; m_act = 0; m_idx = 0;
      e_valid = 0; e_word = 0; e_tag = "R13"; started = 1;
    end else begin
      w = in_word;
      if (trs && in_word <= 10'h003) w = 10'h000;
      if (trs && in_word >= 10'h3FC) w = 10'h3FF;
      e_valid = in_valid; e_word = w;
      e_tag = trs ? "R2" : cur_req;
      if (!(edh_en_n || resync) && in_valid && edh_slot && m_idx < 6 && (force_new || m_ok)) begin
        e_word = payload(m_idx);
        e_tag = pos_tag(m_idx);
      end
      if (edh_en_n || resync) begin
        m_acc_a = 0; m_acc_f = 0; m_held_a = 0; m_held_f = 0;
        m_ok = 0; m_act = 0; m_idx = 0;
      end else begin
        if (in_valid) m_idx = edh_slot ? ((m_idx < 6) ? m_idx + 1 : 6) : 0;
        if (in_valid && !trs && !edh_slot) begin
          if (m_act) m_acc_a = crc_of(m_acc_a, w);
          m_acc_f = crc_of(m_acc_f, w);
        end
        if (field_end) begin
          m_held_a = m_acc_a; m_held_f = m_acc_f; m_acc_a = 0; m_acc_f = 0; m_ok = 1;
        end
        if (in_valid && sav) m_act = !vblank;
        else if (in_valid && eav) m_act = 0;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      n_chk++;
      if (out_valid !== e_valid || (e_valid && out_word !== e_word) ||
          (!e_valid && rst === 1'b0 && 0) || (e_tag == "R13" && out_word !== e_word)) begin
        n_fail++;
        $display("FAIL %s: valid=%0b word=%03h expected valid=%0b word=%03h",
                 e_tag, out_valid, out_word, e_valid, e_word);
      end
    end
  end

  task automatic put(input logic [9:0] w, input bit t, input bit s, input bit e, input bit sl);
    @(negedge clk);
    in_valid = 1; in_word = w; trs = t; sav = s; eav = e; edh_slot = sl;
    field_end = 0; resync = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; trs = 0; sav = 0; eav = 0; edh_slot = 0; field_end = 0; resync = 0;
  endtask

  task automatic pulse_fe();
    idle(); field_end = 1;
  endtask

  task automatic pulse_resync();
    idle(); resync = 1;
  endtask

  task automatic line(input bit vb, input bit anc);
    vblank = vb;
    put(10'h3FD, 1, 0, 0, 0);            // clipped to 3FF (R2)
    put(10'h002, 1, 0, 0, 0);            // clipped to 000 (R2)
    put(10'h001, 1, 0, 0, 0);
    put(10'h274, 1, 0, 1, 0);            // EAV
    for (int i = 0; i < 3; i++) put(10'($urandom), 0, 0, 0, 0);
    if (anc) for (int i = 0; i < 7; i++) put(10'($urandom), 0, 0, 0, 1);
    put(10'h3FF, 1, 0, 0, 0);
    put(10'h000, 1, 0, 0, 0);
    put(10'h003, 1, 0, 0, 0);
    put(10'h200, 1, 1, 0, 0);            // SAV
    for (int i = 0; i < 8; i++) put(10'($urandom), 0, 0, 0, 0);
    idle();
  endtask

  task automatic field(input int nl, input int anc_line);
    for (int l = 0; l < nl; l++) line(l < 2, l == anc_line);
    pulse_fe();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R13: reset state is checked on every reset cycle above
    cur_req = "R9";  field(5, 1);        // slot before any completed field passes through
    cur_req = "R1";  field(5, 1);        // inserts captured values of previous field
    field(6, 3);
    // R6: field boundary in the same cycle as a counted word
    line(0, 0);
    put(10'h155, 0, 0, 0, 0); field_end = 1;
    field(4, 1);
    cur_req = "R12"; line(0, 0); pulse_resync(); field(4, 1); field(4, 1);
    cur_req = "R10"; force_new = 1; pulse_resync(); field(4, 1); field(4, 1);
    force_new = 0;
    cur_req = "R11"; edh_en_n = 1; field(4, 1); field(4, 1);
    edh_en_n = 0; field(4, 1); field(4, 1);
    repeat (3) idle();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule